// File: doc/BRIEF.md
# DMA Channel Bus Arbiter with Exclusive Ownership

This block decides which of several DMA channels drives a single shared master bus port. Each channel presents a request, a priority, a suspend control and an exclusive-ownership setting. The arbiter issues a registered one-hot grant and a grant-valid flag. It re-arbitrates only at transaction boundaries, which the granted channel signals with end pulses. It never pre-empts a channel in the middle of a transaction.

A channel can ask for exclusive ownership when it is granted. The ownership then lasts over one of three scopes: the current transaction, the current block, or the whole transfer. While a channel holds ownership, transaction boundaries that fall inside the chosen scope do not let other channels in. A suspended channel cannot win the bus. A granted channel that is suspended, or that withdraws its request, loses the bus and any ownership it holds at the next edge. A build parameter can remove the ownership logic altogether.

Top module: `dma_lock_arbiter`

## Requirements
- R1: After reset `gnt_o` is all zeros and `gnt_valid_o` is 0.
- R2: When the arbiter re-arbitrates, the new grant appears on the next clock edge. It goes to the requesting, non-suspended channel with the numerically largest priority (field `prio_i[c*3 +: 3]`, where 7 is the highest). `gnt_o` is one-hot or zero, and `gnt_valid_o` is high exactly when a grant is present.
- R3: Equal priorities are resolved in favour of the lower channel index.
- R4: Without exclusive ownership, the owner keeps the grant until one of the following happens: any end pulse (`txn_end_i`, `blk_end_i`, `xfer_end_i`), its request falls, or it is suspended. Only then is arbitration re-run. A higher-priority request that arrives mid-transaction does not pre-empt the owner.
- R5: With no eligible requester at re-arbitration, `gnt_o` becomes zero and `gnt_valid_o` becomes 0.
- R6: A channel with `susp_i[c]`=1 is never granted.
- R7: A winner with `own_en_i[c]`=1 and scope `own_lvl_i[c*2 +: 2]` = 2'b10 or 2'b11 (transaction) gives up ownership at the next `txn_end_i`.
- R8: Scope 2'b01 (block) keeps the grant across `txn_end_i` pulses. It is released on `blk_end_i` or `xfer_end_i`.
- R9: Scope 2'b00 (transfer) keeps the grant across `txn_end_i` and `blk_end_i`. It is released only on `xfer_end_i`.
- R10: An owner that drops its request or is suspended loses the grant and its ownership at the next edge, whatever its scope.
- R11: With `LOCK_EN`=0, `own_en_i` and `own_lvl_i` have no effect, and every end pulse is a re-arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Per-channel bus request |
| prio_i | input | NUM_CH*PRIO_W | Per-channel priority, packed by channel |
| own_en_i | input | NUM_CH | Per-channel exclusive-ownership enable |
| own_lvl_i | input | NUM_CH*2 | Per-channel ownership scope, packed by channel |
| susp_i | input | NUM_CH | Per-channel suspend |
| txn_end_i | input | 1 | Owner finished a transaction (pulse) |
| blk_end_i | input | 1 | Owner finished a block (pulse) |
| xfer_end_i | input | 1 | Owner finished its transfer (pulse) |
| gnt_o | output | NUM_CH | Registered one-hot grant |
| gnt_valid_o | output | 1 | A grant is present |

## Verification
Two functions can fall in the same cycle: the release of block-scoped ownership and the suspension of the channel that would otherwise take the bus. The bench provokes this by raising `blk_end_i` together with `susp_i` of the highest-priority waiting channel. The grant must then pass to the next-best waiting channel, not to the suspended one and not back to the old owner. The bench also runs a second instance built without ownership logic on the same stimulus. At each boundary, the grants of the two instances must differ exactly where the ownership scope says they should.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    SCOPE_XFER = 2'b00,
    SCOPE_BLK  = 2'b01,
    SCOPE_TXN  = 2'b10
  } own_scope_e;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        cand_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic [NUM_CH-1:0]        win_oh_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic                     win_vld_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: lower index keeps ties
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    best_p    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cand_i[i] && (!win_vld_o || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        best_p    = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    win_oh_o = '0;
    if (win_vld_o) win_oh_o[win_idx_o] = 1'b1;
  end
endmodule

// File: rtl/dma_arb_own.sv
module dma_arb_own
  import dma_arb_pkg::*;
#(
  parameter bit LOCK_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       set_i,
  input  logic [1:0] lvl_i,
  input  logic       txn_end_i,
  input  logic       blk_end_i,
  input  logic       xfer_end_i,
  output logic       active_o,
  output logic       hold_o
);
  generate
    if (LOCK_EN) begin : g_own
      logic       own_q;
      logic [1:0] lvl_q;
      logic       match;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          own_q <= 1'b0;
          lvl_q <= SCOPE_XFER;
        end else if (load_i) begin
          own_q <= set_i;
          lvl_q <= lvl_i;
        end
      end

      // scope 1x -> transaction, 01 -> block, 00 -> transfer
      always_comb begin
        if (lvl_q[1])      match = txn_end_i;
        else if (lvl_q[0]) match = blk_end_i;
        else               match = 1'b0;
      end

      assign active_o = own_q;
      assign hold_o   = own_q && !match && !xfer_end_i;
    end else begin : g_no_own
      logic unused_own;
      assign unused_own = ^{clk_i, rst_ni, load_i, set_i, lvl_i,
                            txn_end_i, blk_end_i, xfer_end_i};
      assign active_o = 1'b0;
      assign hold_o   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_lock_arbiter.sv
module dma_lock_arbiter #(
  parameter int NUM_CH  = 4,
  parameter int PRIO_W  = 3,
  parameter bit LOCK_EN = 1'b1,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH-1:0]        own_en_i,
  input  logic [NUM_CH*2-1:0]      own_lvl_i,
  input  logic [NUM_CH-1:0]        susp_i,
  input  logic                     txn_end_i,
  input  logic                     blk_end_i,
  input  logic                     xfer_end_i,
  output logic [NUM_CH-1:0]        gnt_o,
  output logic                     gnt_valid_o
);
  logic [NUM_CH-1:0] gnt_q;
  logic [NUM_CH-1:0] win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic              win_vld;
  logic              have, owner_req, owner_susp, boundary;
  logic              own_active, own_hold, rearb;

  dma_arb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick (
    .cand_i    (req_i & ~susp_i),
    .prio_i    (prio_i),
    .win_oh_o  (win_oh),
    .win_idx_o (win_idx),
    .win_vld_o (win_vld)
  );

  assign have       = |gnt_q;
  assign owner_req  = |(gnt_q & req_i);
  assign owner_susp = |(gnt_q & susp_i);
  assign boundary   = txn_end_i | blk_end_i | xfer_end_i;

  // re-arbitrate when idle, owner gone, or at a boundary not covered by ownership
  assign rearb = !have || !owner_req || owner_susp || (boundary && !own_hold);

  dma_arb_own #(.LOCK_EN(LOCK_EN)) u_own (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rearb),
    .set_i      (win_vld && own_en_i[win_idx]),
    .lvl_i      (own_lvl_i[win_idx*2 +: 2]),
    .txn_end_i  (txn_end_i),
    .blk_end_i  (blk_end_i),
    .xfer_end_i (xfer_end_i),
    .active_o   (own_active),
    .hold_o     (own_hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gnt_q <= '0;
    else if (rearb) gnt_q <= win_oh;
  end

  assign gnt_o       = gnt_q;
  assign gnt_valid_o = have;
endmodule

module dma_lock_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] susp_i,
  input logic              txn_end_i,
  input logic              blk_end_i,
  input logic              xfer_end_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic              gnt_valid_o,
  input logic              own_hold
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R2
  gnt_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o == (gnt_o != '0));
  // R6
  no_susp_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(gnt_o) && gnt_o != '0 |-> (gnt_o & $past(susp_i)) == '0);
  // R2
  gnt_had_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(gnt_o) && gnt_o != '0 |-> (gnt_o & $past(req_i)) != '0);
  // R4
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & req_i) != '0 && (gnt_o & susp_i) == '0
    && !txn_end_i && !blk_end_i && !xfer_end_i |=> $stable(gnt_o));
  // R8
  own_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_hold && (gnt_o & req_i) != '0 && (gnt_o & susp_i) == '0
    |=> $stable(gnt_o));
endmodule

bind dma_lock_arbiter dma_lock_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .susp_i      (susp_i),
  .txn_end_i   (txn_end_i),
  .blk_end_i   (blk_end_i),
  .xfer_end_i  (xfer_end_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o),
  .own_hold    (own_hold)
);

// File: tb/dma_lock_arbiter_tb.sv
`timescale 1ns/1ps
module dma_lock_arbiter_tb;
  localparam int N = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, own_en = '0, susp = '0;
  logic [N*PW-1:0] prio = '0;
  logic [N*2-1:0]  lvl = '0;
  logic          txn_end = 1'b0, blk_end = 1'b0, xfer_end = 1'b0;
  logic [N-1:0]  gnt, gnt_nl;
  logic          gvld, gvld_nl;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  dma_lock_arbiter #(.NUM_CH(N), .PRIO_W(PW), .LOCK_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio), .own_en_i(own_en),
    .own_lvl_i(lvl), .susp_i(susp), .txn_end_i(txn_end), .blk_end_i(blk_end),
    .xfer_end_i(xfer_end), .gnt_o(gnt), .gnt_valid_o(gvld));

  dma_lock_arbiter #(.NUM_CH(N), .PRIO_W(PW), .LOCK_EN(1'b0)) u_dut_nl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio), .own_en_i(own_en),
    .own_lvl_i(lvl), .susp_i(susp), .txn_end_i(txn_end), .blk_end_i(blk_end),
    .xfer_end_i(xfer_end), .gnt_o(gnt_nl), .gnt_valid_o(gvld_nl));

  task automatic chk(input string r, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input bit t, input bit b, input bit x);
    txn_end = t; blk_end = b; xfer_end = x;
    step();
    txn_end = 0; blk_end = 0; xfer_end = 0;
  endtask

  task automatic setp(input int ch, input int p);
    prio[ch*PW +: PW] = PW'(p);
  endtask

  task automatic idle();
    req = '0; susp = '0; own_en = '0; lvl = '0; prio = '0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 gnt", gnt, 4'b0000);
    chk("R1 valid", {3'b0, gvld}, 4'b0000);
  endtask

  task automatic t_prio();
    idle();
    setp(0, 1); setp(2, 3); req = 4'b0101;
    step();
    chk("R2 highest prio", gnt, 4'b0100);
    chk("R2 valid", {3'b0, gvld}, 4'b0001);
  endtask

  task automatic t_tie();
    idle();
    setp(1, 2); setp(3, 2); req = 4'b1010;
    step();
    chk("R3 tie low index", gnt, 4'b0010);
  endtask

  task automatic t_no_preempt();
    idle();
    setp(0, 0); setp(3, 3); req = 4'b0001;
    step();
    chk("R4 first owner", gnt, 4'b0001);
    req = 4'b1001;
    step();
    chk("R4 no preempt", gnt, 4'b0001);
    pulse(1, 0, 0);
    chk("R4 rearb at boundary", gnt, 4'b1000);
  endtask

  task automatic t_none();
    idle();
    chk("R5 no grant", gnt, 4'b0000);
    chk("R5 valid low", {3'b0, gvld}, 4'b0000);
  endtask

  task automatic t_susp();
    idle();
    setp(1, 3); setp(2, 1); req = 4'b0110; susp = 4'b0010;
    step();
    chk("R6 suspended skipped", gnt, 4'b0100);
  endtask

  task automatic t_lock_txn();
    idle();
    setp(1, 3); own_en = 4'b0001; lvl[1:0] = 2'b10; req = 4'b0001;
    step();
    req = 4'b0011;
    step();
    chk("R7 held mid txn", gnt, 4'b0001);
    pulse(1, 0, 0);
    chk("R7 release at txn end", gnt, 4'b0010);
  endtask

  task automatic t_lock_blk();
    idle();
    setp(1, 3); own_en = 4'b0001; lvl[1:0] = 2'b01; req = 4'b0001;
    step();
    req = 4'b0011;
    pulse(1, 0, 0);
    chk("R8 held across txn end", gnt, 4'b0001);
    chk("R11 no-own moves at txn end", gnt_nl, 4'b0010);
    pulse(1, 1, 0);
    chk("R8 release at blk end", gnt, 4'b0010);
  endtask

  task automatic t_lock_xfer();
    idle();
    setp(1, 3); own_en = 4'b0001; lvl[1:0] = 2'b00; req = 4'b0001;
    step();
    req = 4'b0011;
    pulse(1, 0, 0);
    chk("R9 held across txn end", gnt, 4'b0001);
    pulse(1, 1, 0);
    chk("R9 held across blk end", gnt, 4'b0001);
    pulse(1, 1, 1);
    chk("R9 release at xfer end", gnt, 4'b0010);
  endtask

  task automatic t_drop();
    idle();
    setp(1, 3); own_en = 4'b0001; lvl[1:0] = 2'b00; req = 4'b0001;
    step();
    req = 4'b0011;
    step();
    req = 4'b0010;
    step();
    chk("R10 owner drop releases", gnt, 4'b0010);
    idle();
    setp(1, 3); own_en = 4'b0001; lvl[1:0] = 2'b00; req = 4'b0001;
    step();
    req = 4'b0011; susp = 4'b0001;
    step();
    chk("R10 owner suspend releases", gnt, 4'b0010);
  endtask

  // block-scope release coinciding with suspend of the best waiting channel
  task automatic t_release_and_susp();
    idle();
    setp(1, 5); setp(2, 3); own_en = 4'b0001; lvl[1:0] = 2'b01; req = 4'b0001;
    step();
    req = 4'b0111;
    pulse(1, 0, 0);
    chk("R8 held before collision", gnt, 4'b0001);
    susp = 4'b0010;
    pulse(1, 1, 0);
    chk("R6 release with suspend", gnt, 4'b0100);
  endtask

  initial begin
    #20;
    t_reset();
    rst_n = 1'b1;
    #3;
    t_prio();
    t_tie();
    t_no_preempt();
    t_none();
    t_susp();
    t_lock_txn();
    t_lock_blk();
    t_lock_xfer();
    t_drop();
    t_release_and_susp();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule